// File: doc/BRIEF.md
# Static Memory Write Timing Generator

This block drives one write access at a time onto an external asynchronous static memory bus. Timing is counted in clock cycles. Every chip select has its own timing set: a setup count, a pulse count and a total cycle count for the write strobe, and the same three counts for the chip select. A control bit chooses which of the two signals sets the moment the data bus starts to be driven. From the timing set of the selected chip select, the block produces the active-low chip select lines, the active-low write strobe, the address, the active-low byte selects, the write data and the data-bus output enable.

A client offers a write with a valid/ready handshake. The write carries the chip select index, the address, the data and the byte enables. The block captures the write together with the timing set of the target chip select. It then plays out the waveform and raises a one-cycle done pulse in the final cycle of the access. The hold time of each signal is not programmed directly. It is whatever is left of the access after setup plus pulse.

Top module: `smc_write_timing_gen`

## Requirements
- R1: After a cycle with `rst` high, all chip select lines and the write strobe are high, the output enable and done are low, `req_ready` is high, the address is zero and the byte selects are all high.
- R2: A write is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle through the done cycle and high again in the cycle after done.
- R3: An access lasts C cycles, numbered 0 to C-1 from the cycle after acceptance. C is the largest of the strobe cycle count, the chip-select cycle count, strobe setup plus effective strobe pulse, and chip-select setup plus effective chip-select pulse. `wr_done` is high only in cycle C-1.
- R4: The write strobe is low exactly in access cycles k with setup ≤ k < setup + pulse. A setup of zero lowers it in cycle 0. When setup + pulse = C, it stays low through cycle C-1.
- R5: The chip select line whose index was captured is low exactly in cycles k with cs_setup ≤ k < cs_setup + cs_pulse. Every other chip select line stays high, and at most one line is ever low.
- R6: A programmed pulse count of zero, for either the strobe or the chip select, acts as a pulse of one cycle.
- R7: With the control bit at 1 (strobe-controlled), the output enable is high from cycle strobe-setup through cycle C-1 and low otherwise.
- R8: With the control bit at 0 (chip-select-controlled), the output enable is high from cycle cs_setup through cycle C-1 and low otherwise.
- R9: Address, write data and byte enables are captured at acceptance. They stay stable on `mem_addr`, `mem_wdata` and `mem_be_n` (bit i low means byte i is written) until the next acceptance.
- R10: The timing set and the control bit are sampled at acceptance. Changing the configuration inputs during an access does not change that access's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, ready to accept |
| req_cs | input | SEL_W | Target chip select index |
| req_addr | input | ADDR_W | Write address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit i for byte i |
| cfg_we_setup | input | NUM_CS*CNT_W | Strobe setup counts, slice i for chip select i |
| cfg_we_pulse | input | NUM_CS*CNT_W | Strobe pulse counts |
| cfg_we_cycle | input | NUM_CS*CNT_W | Strobe cycle counts |
| cfg_cs_setup | input | NUM_CS*CNT_W | Chip-select setup counts |
| cfg_cs_pulse | input | NUM_CS*CNT_W | Chip-select pulse counts |
| cfg_cs_cycle | input | NUM_CS*CNT_W | Chip-select cycle counts |
| cfg_ctrl_we | input | NUM_CS | Control bit: 1 strobe controls, 0 chip select controls |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Captured address |
| mem_be_n | output | DATA_W/8 | Active-low byte selects |
| mem_wdata | output | DATA_W | Captured write data |
| mem_data_oe | output | 1 | Data bus output enable |
| wr_done | output | 1 | Last cycle of the access |

## Verification
The bench builds the block with four chip selects, 4-bit timing counts, a 12-bit address and a 16-bit data bus. With 4-bit counts, the largest setup and pulse values sum to 30, which needs the extra counter bit. Short counts also keep the zero-setup, zero-hold, zero-pulse and cycle-shorter-than-setup-plus-pulse cases to a handful of cycles. All four chip select indices are used, so a wrong line being lowered shows up. A behavioural model compares every output on every cycle.

// File: rtl/smc_wr_pkg.sv
package smc_wr_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    typedef enum logic {
        CTRL_BY_CS = 1'b0,
        CTRL_BY_WE = 1'b1
    } wr_ctrl_e;

    // Slots of the latched edge bundle
    localparam int E_WE_ON  = 0;
    localparam int E_WE_OFF = 1;
    localparam int E_CS_ON  = 2;
    localparam int E_CS_OFF = 3;
    localparam int E_OE_ON  = 4;
    localparam int E_LAST   = 5;
    localparam int EDGE_CNT = 6;

    function automatic int unsigned eff_pulse(input int unsigned p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/smc_wr_cfg_sel.sv
module smc_wr_cfg_sel
    import smc_wr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 2,
    parameter int LEN_W  = 7
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_we_setup,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_we_pulse,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_we_cycle,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_cs_setup,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_cs_pulse,
    input  logic [NUM_CS*CNT_W-1:0]   cfg_cs_cycle,
    input  logic [NUM_CS-1:0]         cfg_ctrl_we,
    output logic [EDGE_CNT*LEN_W-1:0] edges_o,
    output logic                      ctrl_o
);

    int                idx;
    logic [CNT_W-1:0]  f_ws, f_wp, f_wc, f_cs, f_cp, f_cc;
    int unsigned       u_we_end, u_cs_end, u_total;

    assign idx = int'(sel);

    always_comb begin
        f_ws = cfg_we_setup[idx*CNT_W +: CNT_W];
        f_wp = cfg_we_pulse[idx*CNT_W +: CNT_W];
        f_wc = cfg_we_cycle[idx*CNT_W +: CNT_W];
        f_cs = cfg_cs_setup[idx*CNT_W +: CNT_W];
        f_cp = cfg_cs_pulse[idx*CNT_W +: CNT_W];
        f_cc = cfg_cs_cycle[idx*CNT_W +: CNT_W];
        ctrl_o = cfg_ctrl_we[sel];

        u_we_end = int'(f_ws) + eff_pulse(int'(f_wp));
        u_cs_end = int'(f_cs) + eff_pulse(int'(f_cp));
        u_total  = max_u(max_u(int'(f_wc), int'(f_cc)), max_u(u_we_end, u_cs_end));

        edges_o = '0;
        edges_o[E_WE_ON*LEN_W  +: LEN_W] = LEN_W'(f_ws);
        edges_o[E_WE_OFF*LEN_W +: LEN_W] = LEN_W'(u_we_end);
        edges_o[E_CS_ON*LEN_W  +: LEN_W] = LEN_W'(f_cs);
        edges_o[E_CS_OFF*LEN_W +: LEN_W] = LEN_W'(u_cs_end);
        edges_o[E_OE_ON*LEN_W  +: LEN_W] = ctrl_o ? LEN_W'(f_ws) : LEN_W'(f_cs);
        edges_o[E_LAST*LEN_W   +: LEN_W] = LEN_W'(u_total - 1);
    end

endmodule

// File: rtl/smc_wr_seq.sv
module smc_wr_seq
    import smc_wr_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [EDGE_CNT*LEN_W-1:0] edges_in,
    output logic                      req_ready,
    output logic                      accept,
    output logic                      active,
    output logic                      done,
    output logic [LEN_W-1:0]          cnt,
    output logic [EDGE_CNT*LEN_W-1:0] edges_q
);

    seq_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] last_q;

    assign last_q    = edges_q[E_LAST*LEN_W +: LEN_W];
    assign req_ready = (state_q == SEQ_IDLE);
    assign accept    = req_ready && req_valid;
    assign active    = (state_q == SEQ_BUSY);
    assign done      = active && (cnt_q == last_q);
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            edges_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        state_q <= SEQ_BUSY;
                        cnt_q   <= '0;
                        edges_q <= edges_in;
                    end
                end
                default: begin
                    if (cnt_q == last_q) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
            endcase
        end
    end

    // R2: the block is ready again right after the last cycle
    assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    // R3: the count never passes the final cycle
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q <= last_q));

    // R2: no second acceptance while an access runs
    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> !req_ready);

endmodule

// File: rtl/smc_wr_strobe.sv
module smc_wr_strobe #(
    parameter int LEN_W = 7
) (
    input  logic             active,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] on_at,
    input  logic [LEN_W-1:0] off_at,
    output logic             asserted
);

    assign asserted = active && (cnt >= on_at) && (cnt < off_at);

endmodule

// File: rtl/smc_wr_capture.sv
module smc_wr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/smc_write_timing_gen.sv
module smc_write_timing_gen
    import smc_wr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [SEL_W-1:0]        req_cs,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [BE_W-1:0]         req_be,
    input  logic [NUM_CS*CNT_W-1:0] cfg_we_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_we_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_we_cycle,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_cycle,
    input  logic [NUM_CS-1:0]       cfg_ctrl_we,
    output logic [NUM_CS-1:0]       mem_cs_n,
    output logic                    mem_we_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BE_W-1:0]         mem_be_n,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    mem_data_oe,
    output logic                    wr_done
);

    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        wr_ctrl_e          ctrl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } payload_t;

    logic [EDGE_CNT*LEN_W-1:0] edges_w, edges_q;
    logic                      ctrl_w;
    logic                      accept, active;
    logic [LEN_W-1:0]          cnt;
    logic                      we_on, cs_on, oe_on;
    logic [LEN_W-1:0]          oe_off;
    payload_t                  pay_d, pay_q;

    smc_wr_cfg_sel #(
        .NUM_CS(NUM_CS), .CNT_W(CNT_W), .SEL_W(SEL_W), .LEN_W(LEN_W)
    ) u_cfg (
        .sel(req_cs),
        .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse), .cfg_we_cycle(cfg_we_cycle),
        .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_cycle(cfg_cs_cycle),
        .cfg_ctrl_we(cfg_ctrl_we),
        .edges_o(edges_w), .ctrl_o(ctrl_w)
    );

    smc_wr_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .edges_in(edges_w),
        .req_ready(req_ready), .accept(accept), .active(active), .done(wr_done),
        .cnt(cnt), .edges_q(edges_q)
    );

    always_comb begin
        pay_d.sel  = req_cs;
        pay_d.ctrl = wr_ctrl_e'(ctrl_w);
        pay_d.addr = req_addr;
        pay_d.data = req_wdata;
        pay_d.be   = req_be;
    end

    smc_wr_capture #(.W($bits(payload_t))) u_cap (
        .clk(clk), .rst(rst), .load(accept), .d(pay_d), .q(pay_q)
    );

    smc_wr_strobe #(.LEN_W(LEN_W)) u_we (
        .active(active), .cnt(cnt),
        .on_at(edges_q[E_WE_ON*LEN_W +: LEN_W]), .off_at(edges_q[E_WE_OFF*LEN_W +: LEN_W]),
        .asserted(we_on)
    );

    smc_wr_strobe #(.LEN_W(LEN_W)) u_cs (
        .active(active), .cnt(cnt),
        .on_at(edges_q[E_CS_ON*LEN_W +: LEN_W]), .off_at(edges_q[E_CS_OFF*LEN_W +: LEN_W]),
        .asserted(cs_on)
    );

    assign oe_off = edges_q[E_LAST*LEN_W +: LEN_W] + LEN_W'(1);

    smc_wr_strobe #(.LEN_W(LEN_W)) u_oe (
        .active(active), .cnt(cnt),
        .on_at(edges_q[E_OE_ON*LEN_W +: LEN_W]), .off_at(oe_off),
        .asserted(oe_on)
    );

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign mem_cs_n[gi] = !(cs_on && (pay_q.sel == SEL_W'(gi)));
    end

    assign mem_we_n    = !we_on;
    assign mem_data_oe = oe_on;
    assign mem_addr    = pay_q.addr;
    assign mem_wdata   = pay_q.data;
    assign mem_be_n    = ~pay_q.be;

    // R1: outputs idle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (&mem_cs_n && mem_we_n && !mem_data_oe && !wr_done && req_ready));

    // R5: never two chip selects at once
    assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R7: in strobe-controlled mode the data bus is driven while the strobe is low
    assert_oe_covers_we_R7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && pay_q.ctrl == CTRL_BY_WE) |-> mem_data_oe);

    // R8: in chip-select-controlled mode the data bus is driven while the select is low
    assert_oe_covers_cs_R8: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && pay_q.ctrl == CTRL_BY_CS) |-> mem_data_oe);

    // R9: captured fields stay put inside an access
    assert_hold_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0) |-> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be_n)));

    // R6: a strobe low in one cycle of an access has a nonzero width even from a zero count
    assert_strobe_present_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (edges_q[E_WE_OFF*LEN_W +: LEN_W] > edges_q[E_WE_ON*LEN_W +: LEN_W]));

endmodule

// File: tb/tb_smc_write_timing_gen.sv
module tb_smc_write_timing_gen;

    localparam int NCS = 4;
    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int CW  = 4;
    localparam int SW  = 2;
    localparam int BW  = DW / 8;
    localparam int CLK_NS = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [SW-1:0] req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic [NCS*CW-1:0] cfg_we_setup = '0, cfg_we_pulse = '0, cfg_we_cycle = '0;
    logic [NCS*CW-1:0] cfg_cs_setup = '0, cfg_cs_pulse = '0, cfg_cs_cycle = '0;
    logic [NCS-1:0] cfg_ctrl_we = '0;
    logic [NCS-1:0] mem_cs_n;
    logic mem_we_n, mem_data_oe, wr_done;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be_n;
    logic [DW-1:0] mem_wdata;

    always #(CLK_NS/2) clk = ~clk;

    smc_write_timing_gen #(.NUM_CS(NCS), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse), .cfg_we_cycle(cfg_we_cycle),
        .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_cycle(cfg_cs_cycle),
        .cfg_ctrl_we(cfg_ctrl_we),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_wdata(mem_wdata), .mem_data_oe(mem_data_oe), .wr_done(wr_done)
    );

    int n_checks = 0;
    int n_fail = 0;
    string note = "reset";

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0h expected %0h at %0t", rq, note, act, exp, $time);
        end
    endtask

    function automatic int fld(input logic [NCS*CW-1:0] v, input int i);
        return int'(v[i*CW +: CW]);
    endfunction

    // ---------------- behavioural reference model ----------------
    bit m_busy = 0, m_seen = 0;
    int m_cnt, m_total, m_ws, m_we_end, m_cs, m_cs_end, m_oe, m_sel;
    bit m_mode, m_wp0, m_cp0;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;
    logic [BW-1:0] m_be;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0;
            m_seen = 0;
            m_cnt  = 0;
        end else if (m_busy) begin
            if (m_cnt == m_total - 1) m_busy = 0;
            else m_cnt++;
        end else if (req_valid) begin
            int wp, cp;
            m_sel  = int'(req_cs);
            m_ws   = fld(cfg_we_setup, m_sel);
            wp     = fld(cfg_we_pulse, m_sel);
            m_wp0  = (wp == 0);
            if (wp == 0) wp = 1;
            m_cs   = fld(cfg_cs_setup, m_sel);
            cp     = fld(cfg_cs_pulse, m_sel);
            m_cp0  = (cp == 0);
            if (cp == 0) cp = 1;
            m_we_end = m_ws + wp;
            m_cs_end = m_cs + cp;
            m_total  = fld(cfg_we_cycle, m_sel);
            if (fld(cfg_cs_cycle, m_sel) > m_total) m_total = fld(cfg_cs_cycle, m_sel);
            if (m_we_end > m_total) m_total = m_we_end;
            if (m_cs_end > m_total) m_total = m_cs_end;
            m_mode = cfg_ctrl_we[m_sel];
            m_oe   = m_mode ? m_ws : m_cs;
            m_addr = req_addr;
            m_data = req_wdata;
            m_be   = req_be;
            m_seen = 1;
            m_busy = 1;
            m_cnt  = 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic e_we_n, e_oe, e_done;
            logic [NCS-1:0] e_cs_n;
            logic [AW-1:0] e_addr;
            logic [BW-1:0] e_be_n;
            e_we_n = !(m_busy && m_cnt >= m_ws && m_cnt < m_we_end);
            e_cs_n = '1;
            if (m_busy && m_cnt >= m_cs && m_cnt < m_cs_end) e_cs_n[m_sel] = 1'b0;
            e_oe   = m_busy && (m_cnt >= m_oe);
            e_done = m_busy && (m_cnt == m_total - 1);
            e_addr = m_seen ? m_addr : '0;
            e_be_n = m_seen ? ~m_be : '1;
            chk(mem_we_n === e_we_n, (m_busy && m_wp0) ? "R6 strobe" : "R4 strobe", 64'(mem_we_n), 64'(e_we_n));
            chk(mem_cs_n === e_cs_n, (m_busy && m_cp0) ? "R6 select" : "R5 select", 64'(mem_cs_n), 64'(e_cs_n));
            chk(mem_data_oe === e_oe, m_mode ? "R7 oe" : "R8 oe", 64'(mem_data_oe), 64'(e_oe));
            chk(wr_done === e_done, "R3 done", 64'(wr_done), 64'(e_done));
            chk(req_ready === !m_busy, "R2 ready", 64'(req_ready), 64'(!m_busy));
            chk(mem_addr === e_addr, "R9 addr", 64'(mem_addr), 64'(e_addr));
            chk(mem_be_n === e_be_n, "R9 be_n", 64'(mem_be_n), 64'(e_be_n));
            if (e_oe) chk(mem_wdata === m_data, "R9 data", 64'(mem_wdata), 64'(m_data));
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_cfg(input int i, input int ws, input int wp, input int wc,
                           input int cs, input int cp, input int cc, input bit md);
        cfg_we_setup[i*CW +: CW] = CW'(ws);
        cfg_we_pulse[i*CW +: CW] = CW'(wp);
        cfg_we_cycle[i*CW +: CW] = CW'(wc);
        cfg_cs_setup[i*CW +: CW] = CW'(cs);
        cfg_cs_pulse[i*CW +: CW] = CW'(cp);
        cfg_cs_cycle[i*CW +: CW] = CW'(cc);
        cfg_ctrl_we[i] = md;
    endtask

    task automatic do_req(input int cs, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
        bit got = 0;
        @(posedge clk); #2;
        req_valid = 1'b1;
        req_cs = SW'(cs);
        req_addr = a;
        req_wdata = d;
        req_be = be;
        while (!got) begin
            @(negedge clk);
            if (req_ready) got = 1;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        set_cfg(0, 2, 3, 8, 1, 5, 8, 1'b1);
        set_cfg(1, 0, 4, 4, 0, 4, 4, 1'b0);
        set_cfg(2, 3, 0, 0, 3, 0, 0, 1'b1);
        set_cfg(3, 5, 6, 2, 1, 2, 3, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs while reset is applied
        chk(mem_cs_n === '1 && mem_we_n === 1'b1, "R1 strobes", {mem_cs_n, mem_we_n}, '1);
        chk(mem_data_oe === 1'b0 && wr_done === 1'b0, "R1 oe/done", {mem_data_oe, wr_done}, 0);
        chk(req_ready === 1'b1 && mem_addr === '0 && mem_be_n === '1, "R1 ready/addr", {req_ready, mem_addr}, 64'h1000);
        @(posedge clk); #2; rst = 1'b0;

        note = "strobe-controlled, setup/hold nonzero";
        do_req(0, 12'h123, 16'hBEEF, 2'b11); wait_idle();
        note = "zero setup and zero hold, select-controlled";
        do_req(1, 12'h456, 16'h1234, 2'b01); wait_idle();
        note = "zero pulse counts clamp to one";
        do_req(2, 12'h789, 16'hA5A5, 2'b10); wait_idle();
        note = "cycle count below setup+pulse";
        do_req(3, 12'hABC, 16'h5A5A, 2'b00); wait_idle();

        note = "request held while busy";
        do_req(0, 12'h001, 16'h0101, 2'b01);
        do_req(3, 12'h002, 16'h0202, 2'b10);
        do_req(1, 12'h003, 16'h0303, 2'b11);
        wait_idle();

        // R10: configuration rewritten in the middle of an access
        note = "R10 mid-access config change";
        set_cfg(2, 1, 4, 9, 2, 3, 9, 1'b0);
        do_req(2, 12'hF0F, 16'hC3C3, 2'b11);
        @(posedge clk); #2;
        set_cfg(2, 0, 1, 1, 0, 1, 1, 1'b1);
        wait_idle();
        do_req(2, 12'h0F0, 16'h3C3C, 2'b01); wait_idle();

        note = "largest counts";
        set_cfg(1, 15, 15, 15, 15, 15, 15, 1'b1);
        do_req(1, 12'hFFF, 16'hFFFF, 2'b11); wait_idle();

        note = "reset mid-access";
        do_req(0, 12'h555, 16'h7777, 2'b10);
        @(posedge clk); #2; rst = 1'b1;
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n === '1 && mem_we_n === 1'b1 && mem_data_oe === 1'b0, "R1 after reset",
            {mem_cs_n, mem_we_n, mem_data_oe}, 64'h3E);
        chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        repeat (3) @(posedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule